// File: doc/BRIEF.md
# Quad Saturating Accumulator Bank

This block keeps four 48-bit accumulators for a multiply-accumulate datapath. Each cycle one accumulator can take a 40-bit product, either added to it or subtracted from it. The operand mode sets how both operands are extended, which overflow test applies, and what value an overflowed result is replaced with when saturation is enabled. Each accumulator has its own sticky overflow bit. These bits are collected into a four-bit vector in which bit n belongs to accumulator n. A shared set of four condition flags describes the result of the latest accumulate.

A separate load port writes a 32-bit value into any accumulator. The value is extended according to the operand mode, and the load clears that accumulator's sticky bit. A clear strobe resets the condition flags. The multiplier that produces the product and the rounded read-out path are not part of this block. All four accumulators are always visible on one flat output bus.

Top module: `macc_quad`

## Requirements
- R1: After reset every accumulator, every sticky bit and all four flags (zero, negative, overflow, extension overflow) read 0.
- R2: A load writes the 32-bit input into the selected accumulator and clears its sticky bit. It leaves the flags unchanged. The mode decides the form: mode 0 (signed integer) and mode 3 sign-extend the value, mode 1 (unsigned integer) zero-extends it, and mode 2 (fractional) sign-extends it and shifts it left by 8 bits.
- R3: An accumulate with the subtract input low adds the product, and with it high subtracts the product. Modes 1 (unsigned) zero-extend both operands and the other modes sign-extend them. A sum that does not overflow is stored as its low 48 bits.
- R4: In signed mode an overflow occurs when the 64-bit sum differs from its low 48 bits sign-extended. With saturation enabled, such a result becomes 0x00007FFFFFFF when the sum is positive and 0xFFFF80000000 when it is negative. With saturation disabled, the low 48 bits are kept.
- R5: In unsigned mode an overflow occurs when any bit at or above bit 48 of the sum is set. With saturation enabled, a sum above 2^53 becomes 0 and any other overflowed sum becomes 0xFFFFFFFFFFFF. With saturation disabled, the result is the sum masked to 48 bits.
- R6: Fractional mode uses the same overflow test as signed mode. With saturation enabled, an overflowed result becomes 0x7FFFFFFFFFFF when the sum is positive and 0x800000000000 when it is negative.
- R7: After an accumulate, the accumulator's sticky bit is set if the overflow flag is set, which is the case on a new overflow or on an overflow flag carried from before. The sticky bit then stays set until a load to that accumulator clears it.
- R8: After an accumulate, the zero flag shows whether the new value is 0. The negative flag shows bit 47 of the new value. The overflow flag shows that accumulator's sticky bit.
- R9: After an accumulate, the extension-overflow flag is set as follows. In fractional mode it is set when bits 47..40 are not all equal. In unsigned mode it is set when bits 47..32 are not all zero. In signed and mode-3 operation it is set when bits 47..32 are not all equal.
- R10: The clear strobe sets all four flags to 0 when no accumulate happens. When it arrives together with an accumulate, the accumulate sets the flags, and no earlier overflow flag carries into the sticky bit.
- R11: If a load and an accumulate target the same accumulator in the same cycle, only the load takes effect, and the flags keep their values. If they target different accumulators, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Accumulate strobe |
| acc_sel | input | 2 | Accumulator targeted by the accumulate |
| acc_sub | input | 1 | 1 subtracts the product, 0 adds it |
| prod | input | 40 | Incoming product |
| mode | input | 2 | 0 signed, 1 unsigned, 2 fractional, 3 as signed |
| omc | input | 1 | Saturation enable on overflow |
| flag_clr | input | 1 | Clears the four flags |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 2 | Accumulator targeted by the load |
| ld_data | input | 32 | Load value |
| acc_all | output | 192 | Accumulator n on bits 48n+47..48n |
| pav | output | 4 | Sticky overflow bit of each accumulator |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_ev | output | 1 | Extension-overflow flag |

## Verification
The properties assume that every control input is a known value from the first clock after reset release. They also assume that the strobes are sampled at the rising edge only, so that a collision between a load and an accumulate is decided by the selects in that same cycle. The stimulus keeps to this: every input is driven to a defined value before reset, inputs change only on falling edges, and both selects always name one of the four accumulators. The random stimulus favours extreme product values, so overflow and saturation in every mode are reached without long directed loops.

// File: rtl/macc_quad_pkg.sv
package macc_quad_pkg;
  typedef enum logic [1:0] {
    MD_SINT = 2'd0,
    MD_UINT = 2'd1,
    MD_FRAC = 2'd2,
    MD_RSVD = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic ev;
  } acc_flags_t;
endpackage

// File: rtl/macc_sum_unit.sv
module macc_sum_unit
  import macc_quad_pkg::*;
#(
  parameter int ACC_W       = 48,
  parameter int PROD_W      = 40,
  parameter int SUM_W       = 64,
  parameter int SINT_W      = 32,
  parameter int UNDER_SHIFT = 5
) (
  input  logic [ACC_W-1:0]  acc_i,
  input  logic [PROD_W-1:0] prod_i,
  input  logic              sub_i,
  input  acc_mode_e         mode_i,
  input  logic              omc_i,
  output logic [ACC_W-1:0]  res_o,
  output logic              ovf_o
);
  localparam int AEXT_W = SUM_W - ACC_W;
  localparam int PEXT_W = SUM_W - PROD_W;
  localparam logic [SUM_W-1:0] UNDER_LIM =
    {{(SUM_W-1){1'b0}}, 1'b1} << (ACC_W + UNDER_SHIFT);

  logic [SUM_W-1:0] acc_x;
  logic [SUM_W-1:0] prod_x;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] low_sext;
  logic [ACC_W-1:0] sat_val;
  logic             is_uns;
  logic             sign;

  always_comb begin
    is_uns   = (mode_i == MD_UINT);
    acc_x    = is_uns ? {{AEXT_W{1'b0}}, acc_i}
                      : {{AEXT_W{acc_i[ACC_W-1]}}, acc_i};
    prod_x   = is_uns ? {{PEXT_W{1'b0}}, prod_i}
                      : {{PEXT_W{prod_i[PROD_W-1]}}, prod_i};
    sum      = sub_i ? (acc_x - prod_x) : (acc_x + prod_x);
    sign     = sum[SUM_W-1];
    low_sext = {{AEXT_W{sum[ACC_W-1]}}, sum[ACC_W-1:0]};
    case (mode_i)
      MD_UINT: begin
        ovf_o   = |sum[SUM_W-1:ACC_W];
        sat_val = (sum > UNDER_LIM) ? '0 : '1;
      end
      MD_FRAC: begin
        ovf_o   = (sum != low_sext);
        sat_val = {sign, {(ACC_W-1){~sign}}};
      end
      default: begin
        ovf_o   = (sum != low_sext);
        sat_val = {{(ACC_W-SINT_W+1){sign}}, {(SINT_W-1){~sign}}};
      end
    endcase
    res_o = (ovf_o && omc_i) ? sat_val : sum[ACC_W-1:0];
  end
endmodule

// File: rtl/macc_flag_eval.sv
module macc_flag_eval
  import macc_quad_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int SINT_W = 32,
  parameter int FRAC_W = 40
) (
  input  logic [ACC_W-1:0] val_i,
  input  acc_mode_e        mode_i,
  output logic             z_o,
  output logic             n_o,
  output logic             ev_o
);
  logic [ACC_W-SINT_W-1:0] hi_int;
  logic [ACC_W-FRAC_W-1:0] hi_frac;

  always_comb begin
    hi_int  = val_i[ACC_W-1:SINT_W];
    hi_frac = val_i[ACC_W-1:FRAC_W];
    z_o     = (val_i == '0);
    n_o     = val_i[ACC_W-1];
    case (mode_i)
      MD_UINT: ev_o = |hi_int;
      MD_FRAC: ev_o = !((&hi_frac) || (~|hi_frac));
      default: ev_o = !((&hi_int) || (~|hi_int));
    endcase
  end
endmodule

// File: rtl/macc_bank.sv
module macc_bank #(
  parameter int N_ACC = 4,
  parameter int ACC_W = 48
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_ACC-1:0]       ld_hit,
  input  logic [ACC_W-1:0]       ld_val,
  input  logic [N_ACC-1:0]       ac_hit,
  input  logic [ACC_W-1:0]       ac_val,
  input  logic [N_ACC-1:0]       pav_set,
  output logic [N_ACC*ACC_W-1:0] acc_flat,
  output logic [N_ACC-1:0]       pav_o
);
  for (genvar g = 0; g < N_ACC; g++) begin : g_slot
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] acc_d;
    logic             acc_ce;
    logic             pav_q;
    logic             pav_d;

    always_comb begin
      acc_ce = ld_hit[g] | ac_hit[g];
      acc_d  = ld_hit[g] ? ld_val : ac_val;
      pav_d  = ld_hit[g] ? 1'b0 : (pav_q | pav_set[g]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        pav_q <= 1'b0;
      end else begin
        if (acc_ce) acc_q <= acc_d;
        pav_q <= pav_d;
      end
    end

    assign acc_flat[g*ACC_W +: ACC_W] = acc_q;
    assign pav_o[g]                   = pav_q;
  end
endmodule

// File: rtl/macc_quad.sv
module macc_quad
  import macc_quad_pkg::*;
#(
  parameter int N_ACC      = 4,
  parameter int ACC_W      = 48,
  parameter int PROD_W     = 40,
  parameter int LD_W       = 32,
  parameter int FRAC_SHIFT = 8,
  parameter int SINT_W     = 32,
  parameter int SUM_W      = 64,
  parameter int SEL_W      = $clog2(N_ACC)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_en,
  input  logic [SEL_W-1:0]       acc_sel,
  input  logic                   acc_sub,
  input  logic [PROD_W-1:0]      prod,
  input  logic [1:0]             mode,
  input  logic                   omc,
  input  logic                   flag_clr,
  input  logic                   ld_en,
  input  logic [SEL_W-1:0]       ld_sel,
  input  logic [LD_W-1:0]        ld_data,
  output logic [N_ACC*ACC_W-1:0] acc_all,
  output logic [N_ACC-1:0]       pav,
  output logic                   flag_z,
  output logic                   flag_n,
  output logic                   flag_v,
  output logic                   flag_ev
);
  localparam int FRAC_W  = ACC_W - FRAC_SHIFT;
  localparam int LEXT_W  = ACC_W - LD_W;
  localparam int FEXT_W  = ACC_W - LD_W - FRAC_SHIFT;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  acc_mode_e        md;
  logic [ACC_W-1:0] acc_cur;
  logic             pav_cur;
  logic [ACC_W-1:0] ld_val;
  logic [N_ACC-1:0] ld_hit;
  logic [N_ACC-1:0] ac_hit;
  logic [N_ACC-1:0] pav_set;
  logic             acc_do;
  logic [ACC_W-1:0] sum_res;
  logic             sum_ovf;
  logic             res_z;
  logic             res_n;
  logic             res_ev;
  logic             v_prior;
  logic             v_after;
  acc_flags_t       flags_q;
  acc_flags_t       flags_d;
  logic             flags_ce;

  assign md = acc_mode_e'(mode);

  // operand select and write decode
  always_comb begin
    acc_cur = '0;
    pav_cur = 1'b0;
    for (int i = 0; i < N_ACC; i++) begin
      if (acc_sel == SEL_W'(i)) begin
        acc_cur = acc_all[i*ACC_W +: ACC_W];
        pav_cur = pav[i];
      end
      ld_hit[i] = ld_en && (ld_sel == SEL_W'(i));
      ac_hit[i] = acc_en && (acc_sel == SEL_W'(i)) && !ld_hit[i];
    end
    acc_do = |ac_hit;
  end

  // load value formatting
  always_comb begin
    case (md)
      MD_UINT: ld_val = {{LEXT_W{1'b0}}, ld_data};
      MD_FRAC: ld_val = {{FEXT_W{ld_data[LD_W-1]}}, ld_data, {FRAC_SHIFT{1'b0}}};
      default: ld_val = {{LEXT_W{ld_data[LD_W-1]}}, ld_data};
    endcase
  end

  macc_sum_unit #(
    .ACC_W (ACC_W),
    .PROD_W(PROD_W),
    .SUM_W (SUM_W),
    .SINT_W(SINT_W)
  ) u_sum (
    .acc_i (acc_cur),
    .prod_i(prod),
    .sub_i (acc_sub),
    .mode_i(md),
    .omc_i (omc),
    .res_o (sum_res),
    .ovf_o (sum_ovf)
  );

  macc_flag_eval #(
    .ACC_W (ACC_W),
    .SINT_W(SINT_W),
    .FRAC_W(FRAC_W)
  ) u_flag (
    .val_i (sum_res),
    .mode_i(md),
    .z_o   (res_z),
    .n_o   (res_n),
    .ev_o  (res_ev)
  );

  // sticky overflow and flag next state
  always_comb begin
    v_prior  = flags_q.v & ~flag_clr;
    v_after  = sum_ovf | v_prior;
    pav_set  = ac_hit & {N_ACC{v_after}};
    flags_ce = acc_do | flag_clr;
    if (acc_do) begin
      flags_d.z  = res_z;
      flags_d.n  = res_n;
      flags_d.v  = pav_cur | v_after;
      flags_d.ev = res_ev;
    end else begin
      flags_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)   flags_q <= '0;
    else if (flags_ce) flags_q <= flags_d;
  end

  macc_bank #(
    .N_ACC(N_ACC),
    .ACC_W(ACC_W)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .ld_hit  (ld_hit),
    .ld_val  (ld_val),
    .ac_hit  (ac_hit),
    .ac_val  (sum_res),
    .pav_set (pav_set),
    .acc_flat(acc_all),
    .pav_o   (pav)
  );

  assign flag_z  = flags_q.z;
  assign flag_n  = flags_q.n;
  assign flag_v  = flags_q.v;
  assign flag_ev = flags_q.ev;
endmodule

// File: rtl/macc_quad_chk.sv
module macc_quad_chk #(
  parameter int N_ACC = 4,
  parameter int ACC_W = 48,
  parameter int SEL_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_en,
  input logic [SEL_W-1:0]       acc_sel,
  input logic                   flag_clr,
  input logic                   ld_en,
  input logic [SEL_W-1:0]       ld_sel,
  input logic [N_ACC*ACC_W-1:0] acc_all,
  input logic [N_ACC-1:0]       pav,
  input logic                   flag_z,
  input logic                   flag_n,
  input logic                   flag_v,
  input logic                   flag_ev
);
  logic [N_ACC-1:0] ld_mask;
  logic [SEL_W-1:0] sel_q;
  logic [ACC_W-1:0] word_q;
  logic             acc_take;

  always_comb begin
    word_q = '0;
    for (int i = 0; i < N_ACC; i++) begin
      ld_mask[i] = ld_en && (ld_sel == SEL_W'(i));
      if (sel_q == SEL_W'(i)) word_q = acc_all[i*ACC_W +: ACC_W];
    end
    acc_take = acc_en && !(ld_en && (ld_sel == acc_sel));
  end

  always_ff @(posedge clk) sel_q <= acc_sel;

  p_load_clears_pav_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ld_en) |-> !pav[$past(ld_sel)]);

  p_pav_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(pav) & ~$past(ld_mask)) & ~pav) == '0);

  p_v_tracks_pav_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_take) |-> (flag_v == pav[sel_q]));

  p_n_z_value_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_take) |-> ((flag_n == word_q[ACC_W-1]) && (flag_z == (word_q == '0))));

  p_z_excludes_n_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_z |-> !flag_n);

  p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flag_clr && !acc_take) |-> !(flag_z || flag_n || flag_v || flag_ev));

  p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!acc_take && !flag_clr) |-> $stable({flag_z, flag_n, flag_v, flag_ev}));
endmodule

bind macc_quad macc_quad_chk #(
  .N_ACC(N_ACC),
  .ACC_W(ACC_W),
  .SEL_W(SEL_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .acc_en  (acc_en),
  .acc_sel (acc_sel),
  .flag_clr(flag_clr),
  .ld_en   (ld_en),
  .ld_sel  (ld_sel),
  .acc_all (acc_all),
  .pav     (pav),
  .flag_z  (flag_z),
  .flag_n  (flag_n),
  .flag_v  (flag_v),
  .flag_ev (flag_ev)
);

// File: tb/tb_macc_quad.sv
module tb_macc_quad;
  localparam int CLK_PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         acc_en;
  logic [1:0]   acc_sel;
  logic         acc_sub;
  logic [39:0]  prod;
  logic [1:0]   mode;
  logic         omc;
  logic         flag_clr;
  logic         ld_en;
  logic [1:0]   ld_sel;
  logic [31:0]  ld_data;
  logic [191:0] acc_all;
  logic [3:0]   pav;
  logic         flag_z, flag_n, flag_v, flag_ev;

  macc_quad dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_sel(acc_sel),
    .acc_sub(acc_sub), .prod(prod), .mode(mode), .omc(omc),
    .flag_clr(flag_clr), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .acc_all(acc_all), .pav(pav), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_ev(flag_ev)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [47:0] m_acc [4];
  logic [3:0]  m_pav;
  logic        m_z, m_n, m_v, m_ev;
  logic        m_last_ovf;

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [47:0] m_load(logic [31:0] d, logic [1:0] md);
    if (md == 2'd1)      return {16'h0, d};
    else if (md == 2'd2) return {{8{d[31]}}, d, 8'h00};
    else                 return {{16{d[31]}}, d};
  endfunction

  function automatic logic m_evf(logic [47:0] r, logic [1:0] md);
    if (md == 2'd1)      return r[47:32] != 16'h0;
    else if (md == 2'd2) return (r[47:40] != 8'h00) && (r[47:40] != 8'hFF);
    else                 return (r[47:32] != 16'h0) && (r[47:32] != 16'hFFFF);
  endfunction

  task automatic m_accum(input logic [47:0] a, input logic [39:0] p, input logic sb,
                         input logic [1:0] md, input logic om,
                         output logic [47:0] r, output logic ovf);
    if (md == 2'd1) begin
      logic [63:0] ua, up, s;
      ua  = {16'h0, a};
      up  = {24'h0, p};
      s   = sb ? ua - up : ua + up;
      ovf = s >= 64'h0001_0000_0000_0000;
      if (ovf && om) r = (s > 64'h0020_0000_0000_0000) ? 48'h0 : 48'hFFFF_FFFF_FFFF;
      else           r = s[47:0];
    end else begin
      longint sa, sp, s;
      sa  = longint'($signed(a));
      sp  = longint'($signed(p));
      s   = sb ? sa - sp : sa + sp;
      ovf = (s > 64'sd140737488355327) || (s < -64'sd140737488355328);
      if (ovf && om) begin
        if (md == 2'd2) r = (s < 0) ? 48'h8000_0000_0000 : 48'h7FFF_FFFF_FFFF;
        else            r = (s < 0) ? 48'hFFFF_8000_0000 : 48'h0000_7FFF_FFFF;
      end else begin
        r = s[47:0];
      end
    end
  endtask

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    for (int i = 0; i < 4; i++) chk("R3 accumulator value", acc_all[i*48 +: 48], m_acc[i]);
    chk("R7 sticky bits", {44'h0, pav}, {44'h0, m_pav});
    chk("R8 z/n/v flags", {45'h0, flag_z, flag_n, flag_v}, {45'h0, m_z, m_n, m_v});
    chk("R9 extension flag", {47'h0, flag_ev}, {47'h0, m_ev});
  endtask

  task automatic step(input logic ae, input logic [1:0] as, input logic sb,
                      input logic [39:0] pr, input logic [1:0] md, input logic om,
                      input logic cl, input logic le, input logic [1:0] ls,
                      input logic [31:0] ld);
    logic [47:0] r;
    logic        ovf, pn;
    acc_en = ae; acc_sel = as; acc_sub = sb; prod = pr; mode = md; omc = om;
    flag_clr = cl; ld_en = le; ld_sel = ls; ld_data = ld;
    m_last_ovf = 1'b0;
    if (ae && !(le && ls == as)) begin
      m_accum(m_acc[as], pr, sb, md, om, r, ovf);
      m_last_ovf = ovf;
      pn = m_pav[as] | ovf | (m_v & ~cl);
      m_acc[as] = r;
      m_pav[as] = pn;
      m_z = (r == 48'h0); m_n = r[47]; m_v = pn; m_ev = m_evf(r, md);
    end else if (cl) begin
      m_z = 0; m_n = 0; m_v = 0; m_ev = 0;
    end
    if (le) begin
      m_acc[ls] = m_load(ld, md);
      m_pav[ls] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    acc_en = 0; flag_clr = 0; ld_en = 0;
    check_all();
  endtask

  task automatic load(input logic [1:0] s, input logic [31:0] d, input logic [1:0] md);
    step(0, 0, 0, 40'h0, md, 0, 0, 1, s, d);
  endtask

  task automatic accum(input logic [1:0] s, input logic sb, input logic [39:0] p,
                       input logic [1:0] md, input logic om);
    step(1, s, sb, p, md, om, 0, 0, 0, 32'h0);
  endtask

  task automatic run_to_ovf(input logic [1:0] s, input logic sb, input logic [39:0] p,
                            input logic [1:0] md, input logic om);
    for (int k = 0; k < 400; k++) begin
      accum(s, sb, p, md, om);
      if (m_last_ovf) break;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [3:0] fl_before;
    process::self().srandom(32'd20240611);
    rst_n = 0; acc_en = 0; acc_sel = 0; acc_sub = 0; prod = 0; mode = 0; omc = 0;
    flag_clr = 0; ld_en = 0; ld_sel = 0; ld_data = 0;
    for (int i = 0; i < 4; i++) m_acc[i] = 48'h0;
    m_pav = 0; m_z = 0; m_n = 0; m_v = 0; m_ev = 0; m_last_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 reset accumulators", {47'h0, acc_all != 192'h0}, 48'h0);
    chk("R1 reset sticky/flags", {43'h0, pav, flag_z | flag_n | flag_v | flag_ev}, 48'h0);

    // R2 load formats
    load(1, 32'h8000_0000, 2'd0);
    chk("R2 signed load", acc_all[48 +: 48], 48'hFFFF_8000_0000);
    load(1, 32'h8000_0000, 2'd1);
    chk("R2 unsigned load", acc_all[48 +: 48], 48'h0000_8000_0000);
    load(1, 32'h8000_0000, 2'd2);
    chk("R2 fractional load", acc_all[48 +: 48], 48'hFF80_0000_0000);
    chk("R2 flags untouched by load", {44'h0, flag_z, flag_n, flag_v, flag_ev}, 48'h0);

    // R3 add and subtract with extension
    load(0, 32'd5, 2'd0);
    accum(0, 0, 40'd3, 2'd0, 0);
    chk("R3 signed add", acc_all[0 +: 48], 48'd8);
    accum(0, 1, 40'hFF_FFFF_FFFF, 2'd0, 0);
    chk("R3 signed subtract of -1", acc_all[0 +: 48], 48'd9);
    accum(0, 0, 40'hFF_FFFF_FFFF, 2'd1, 0);
    chk("R3 unsigned add zero-extended", acc_all[0 +: 48], 48'h0100_0000_0008);

    // R5 unsigned overflow handling
    load(0, 32'h0, 2'd1);
    step(0, 0, 0, 40'h0, 2'd1, 0, 1, 0, 0, 32'h0);
    accum(0, 1, 40'd1, 2'd1, 1);
    chk("R5 underflow saturates to zero", acc_all[0 +: 48], 48'h0);
    chk("R5 underflow sets V and Z", {46'h0, flag_v, flag_z}, 48'h3);
    load(0, 32'h0, 2'd1);
    chk("R2 load clears sticky", {47'h0, pav[0]}, 48'h0);
    step(0, 0, 0, 40'h0, 2'd1, 0, 1, 0, 0, 32'h0);
    accum(0, 1, 40'd1, 2'd1, 0);
    chk("R5 wrap without saturation", acc_all[0 +: 48], 48'hFFFF_FFFF_FFFF);
    chk("R9 unsigned extension flag", {47'h0, flag_ev}, 48'h1);
    load(0, 32'hFFFF_FFFF, 2'd1);
    run_to_ovf(0, 0, 40'hFF_FFFF_FFFF, 2'd1, 1);
    chk("R5 overflow saturates to all ones", acc_all[0 +: 48], 48'hFFFF_FFFF_FFFF);

    // R4 signed overflow handling
    load(2, 32'h0, 2'd0);
    run_to_ovf(2, 0, 40'h7F_FFFF_FFFF, 2'd0, 1);
    chk("R4 positive saturation", acc_all[96 +: 48], 48'h0000_7FFF_FFFF);
    chk("R7 sticky set on overflow", {47'h0, pav[2]}, 48'h1);
    load(2, 32'h0, 2'd0);
    step(0, 0, 0, 40'h0, 2'd0, 0, 1, 0, 0, 32'h0);
    run_to_ovf(2, 1, 40'h7F_FFFF_FFFF, 2'd0, 1);
    chk("R4 negative saturation", acc_all[96 +: 48], 48'hFFFF_8000_0000);
    load(2, 32'h0, 2'd0);
    step(0, 0, 0, 40'h0, 2'd0, 0, 1, 0, 0, 32'h0);
    run_to_ovf(2, 0, 40'h7F_FFFF_FFFF, 2'd0, 0);
    chk("R4 wrap without saturation", acc_all[96 +: 48], 48'h807F_FFFF_FEFF);
    chk("R8 wrapped value is negative with V", {46'h0, flag_n, flag_v}, 48'h3);

    // R6 fractional saturation
    load(3, 32'h7FFF_FFFF, 2'd2);
    run_to_ovf(3, 0, 40'h7F_FFFF_FFFF, 2'd2, 1);
    chk("R6 positive saturation", acc_all[144 +: 48], 48'h7FFF_FFFF_FFFF);
    load(3, 32'h8000_0000, 2'd2);
    step(0, 0, 0, 40'h0, 2'd2, 0, 1, 0, 0, 32'h0);
    run_to_ovf(3, 1, 40'h7F_FFFF_FFFF, 2'd2, 1);
    chk("R6 negative saturation", acc_all[144 +: 48], 48'h8000_0000_0000);

    // R9 extension flag per mode
    load(1, 32'h7FFF_FFFF, 2'd0);
    accum(1, 0, 40'h00_8000_0001, 2'd0, 0);
    chk("R9 signed extension set", {47'h0, flag_ev}, 48'h1);
    accum(1, 0, 40'h0, 2'd2, 0);
    chk("R9 fractional extension clear", {47'h0, flag_ev}, 48'h0);
    load(1, 32'hFFFF_FFFF, 2'd0);
    accum(1, 0, 40'h0, 2'd0, 0);
    chk("R9 signed all-ones clear", {47'h0, flag_ev}, 48'h0);
    accum(1, 0, 40'h0, 2'd1, 0);
    chk("R9 unsigned all-ones set", {47'h0, flag_ev}, 48'h1);

    // R10 clear strobe
    step(0, 0, 0, 40'h0, 2'd0, 0, 1, 0, 0, 32'h0);
    chk("R10 clear alone", {44'h0, flag_z, flag_n, flag_v, flag_ev}, 48'h0);
    load(2, 32'd5, 2'd1);
    load(1, 32'h0, 2'd1);
    accum(1, 1, 40'd1, 2'd1, 0);
    chk("R7 overflow sets V", {47'h0, flag_v}, 48'h1);
    step(1, 2, 0, 40'h0, 2'd1, 0, 1, 0, 0, 32'h0);
    chk("R10 clear with accumulate drops old V", {47'h0, flag_v}, 48'h0);
    chk("R10 sticky of target stays clear", {47'h0, pav[2]}, 48'h0);

    // R11 collisions
    accum(0, 0, 40'h0, 2'd1, 0);
    fl_before = {flag_z, flag_n, flag_v, flag_ev};
    step(1, 3, 0, 40'd1, 2'd0, 0, 0, 1, 3, 32'h1234_5678);
    chk("R11 load wins on same slot", acc_all[144 +: 48], 48'h0000_1234_5678);
    chk("R11 flags kept on collision", {44'h0, flag_z, flag_n, flag_v, flag_ev},
        {44'h0, fl_before});
    step(1, 1, 0, 40'd1, 2'd0, 0, 0, 1, 0, 32'd7);
    chk("R11 load on other slot", acc_all[0 +: 48], 48'd7);

    // R8 zero result
    load(0, 32'd3, 2'd0);
    accum(0, 1, 40'd3, 2'd0, 0);
    chk("R8 zero flag on zero result", {46'h0, flag_z, flag_n}, 48'h2);

    // random mix
    for (int it = 0; it < 3000; it++) begin
      logic [39:0] p;
      logic [2:0]  pk;
      pk = 3'($urandom_range(0, 7));
      case (pk)
        3'd0: p = 40'h7F_FFFF_FFFF;
        3'd1: p = 40'h80_0000_0000;
        3'd2: p = 40'hFF_FFFF_FFFF;
        3'd3: p = 40'($urandom_range(0, 15));
        default: p = {8'($urandom()), 32'($urandom())};
      endcase
      step(($urandom_range(0, 9) != 0), 2'($urandom_range(0, 3)), 1'($urandom()),
           p, 2'($urandom_range(0, 3)), 1'($urandom()), ($urandom_range(0, 9) == 0),
           ($urandom_range(0, 7) == 0), 2'($urandom_range(0, 3)), 32'($urandom()));
    end

    done = 1;
    summary();
    $finish;
  end
endmodule